// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM that can run either as a 16-bit word memory or as an 8-bit byte memory. The host raises a request with a direction, a mode flag, an address, write data and per-byte lane enables. It keeps that request steady until the controller returns a one-cycle acknowledge. For reads, the read data is valid in the same cycle as the acknowledge. The controller generates the two chip selects, the output enable, the read/write line, the lane strobes and the width-select pin. It also controls a split data bus whose output enable is set pin by pin.

Every analog time limit of the memory is a nanosecond parameter. Each one is rounded up to whole clock periods at elaboration. Read access and read cycle time, write pulse and chip-select-to-end-of-write, data setup, bus release after the output enable or the write strobe, and the width-mode settle time each become a phase length, and one shared down counter times all of them.

In byte mode only the low data lane carries data. The top data pin then becomes the least significant address bit, and the controller drives it as an output for as long as byte mode is in force. When a request asks for the other width, the controller first inserts a guarded mode change: the chip is deselected, the width pin is flipped, and the chip stays deselected until the settle time has passed on both sides of the flip.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and whenever no access is in progress, the chip is deselected: `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1 and `mem_rw`=1. No data pin is driven, `req_ack`=0, and `mem_x16`=1, which selects word mode.
- R2: A read holds `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_rw`=1 for ceil(max(access, cycle)/period) cycles, which is 2 at the defaults. `mem_dq_i` is sampled at the end of the last of those cycles and returned on `rsp_rdata` together with `req_ack`.
- R3: A write holds `mem_rw`=0 with both chip selects active for at least ceil(max(write pulse, select-to-end)/period) cycles, which is 2 at the defaults. It then releases the strobe and the selects together and acknowledges in the following cycle.
- R4: The data lanes stay undriven in the first ceil(release/period) cycles of a write strobe. They are then driven for at least ceil(setup/period) cycles before the strobe ends, and stay driven for one cycle after it ends.
- R5: While `mem_oe_n`=0, and for ceil(release/period) cycles after it rises, the controller drives no data lane.
- R6: In word mode a write strobes only the lanes whose enables are set: `req_be[0]` controls the low byte through `mem_lb_n`, and `req_be[1]` controls the high byte through `mem_ub_n`. A byte whose enable is clear keeps its old value in memory.
- R7: When `mem_x16`=0 (byte mode), pin 15 of the data bus is always driven as an output, pins 14..8 are never driven, and data travels on pins 7..0 only.
- R8: In byte mode `mem_a` = `req_addr[19:1]` and data pin 15 = `req_addr[0]`. Byte-mode reads return the byte in `rsp_rdata[7:0]` with `rsp_rdata[15:8]`=0. In word mode `mem_a` = `req_addr[18:0]`.
- R9: When a request's width (`req_byte`=1 means byte mode) differs from `mem_x16`, the chip stays deselected for at least ceil(settle/period) cycles before `mem_x16` changes and for at least as many cycles after the change before it is selected again.
- R10: A request presented while an access is still finishing is held off and served afterwards. Every request receives exactly one single-cycle acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte-wide access, 0 = word access |
| req_addr | input | 20 | Byte address in byte mode; bits 18..0 are the word address in word mode |
| req_wdata | input | 16 | Write data (bits 7..0 in byte mode) |
| req_be | input | 2 | Word-mode write lane enables, bit 0 low byte |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with the acknowledge of a read |
| mem_a | output | 19 | Memory address pins |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rw | output | 1 | 1 = read, 0 = write strobe |
| mem_lb_n | output | 1 | Low byte lane strobe, active low |
| mem_ub_n | output | 1 | High byte lane strobe, active low |
| mem_x16 | output | 1 | Width select, 1 = word mode, 0 = byte mode |
| mem_dq_o | output | 16 | Data bus output values |
| mem_dq_oe | output | 16 | Per-pin output enable of the data bus |
| mem_dq_i | input | 16 | Data bus input values |

## Verification
The hardest situation to reach is a width change that lands between two accesses while the previous access is still in its turnaround. Here the settle windows on both sides of the flip, the pin-15 address drive and the held-off request all interact. The stimulus forces this by issuing requests back to back, each one presented in the very cycle after the previous acknowledge, and by alternating word and byte requests to the same bytes. The memory model in the bench returns poisoned data if the address has not been stable long enough. It also commits a write with only the data seen in the strobe's last cycle, so timing faults appear as data mismatches.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  localparam int unsigned DQ_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MODE_PRE,
    ST_MODE_POST,
    ST_RD,
    ST_RD_TURN,
    ST_WR_REL,
    ST_WR_DATA,
    ST_WR_HOLD
  } sram_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // driven-data phase of a write: long enough for data setup and,
  // together with the release phase, for the whole strobe minimum
  function automatic int unsigned wr_data_cyc(input int unsigned ds_cyc,
                                              input int unsigned strobe_cyc,
                                              input int unsigned rel_cyc);
    return at_least_one(max2(ds_cyc, (strobe_cyc > rel_cyc) ? strobe_cyc - rel_cyc : 0));
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned RD_CYC   = 2,
  parameter int unsigned HZ_CYC   = 1,
  parameter int unsigned WD_CYC   = 1,
  parameter int unsigned MODE_CYC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_byte,
  input  logic             t_done,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output logic             accept,
  output logic             sample_rd,
  output logic             ack,
  output logic             x16,
  output logic             sel,
  output logic             rd_act,
  output logic             wr_act,
  output logic             drive_data
);
  sram_state_e state, nxt;
  logic wr_q;
  logic flip, ack_set;

  always_comb begin
    nxt       = state;
    t_load    = 1'b0;
    t_val     = '0;
    accept    = 1'b0;
    sample_rd = 1'b0;
    flip      = 1'b0;
    ack_set   = 1'b0;
    case (state)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        t_load = 1'b1;
        if (req_byte == x16) begin
          nxt   = ST_MODE_PRE;
          t_val = CNT_W'(MODE_CYC - 1);
        end else if (req_write) begin
          nxt   = ST_WR_REL;
          t_val = CNT_W'(HZ_CYC - 1);
        end else begin
          nxt   = ST_RD;
          t_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_MODE_PRE: if (t_done) begin
        flip   = 1'b1;
        nxt    = ST_MODE_POST;
        t_load = 1'b1;
        t_val  = CNT_W'(MODE_CYC - 1);
      end
      ST_MODE_POST: if (t_done) begin
        t_load = 1'b1;
        if (wr_q) begin
          nxt   = ST_WR_REL;
          t_val = CNT_W'(HZ_CYC - 1);
        end else begin
          nxt   = ST_RD;
          t_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD: if (t_done) begin
        sample_rd = 1'b1;
        ack_set   = 1'b1;
        nxt       = ST_RD_TURN;
        t_load    = 1'b1;
        t_val     = CNT_W'(HZ_CYC - 1);
      end
      ST_RD_TURN: if (t_done) nxt = ST_IDLE;
      ST_WR_REL: if (t_done) begin
        nxt    = ST_WR_DATA;
        t_load = 1'b1;
        t_val  = CNT_W'(WD_CYC - 1);
      end
      ST_WR_DATA: if (t_done) begin
        nxt     = ST_WR_HOLD;
        ack_set = 1'b1;
      end
      ST_WR_HOLD: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wr_q  <= 1'b0;
      x16   <= 1'b1;
      ack   <= 1'b0;
    end else begin
      state <= nxt;
      ack   <= ack_set;
      if (accept) wr_q <= req_write;
      if (flip)   x16  <= ~x16;
    end
  end

  assign sel        = (state == ST_RD) || (state == ST_WR_REL) || (state == ST_WR_DATA);
  assign rd_act     = (state == ST_RD);
  assign wr_act     = (state == ST_WR_REL) || (state == ST_WR_DATA);
  assign drive_data = (state == ST_WR_DATA) || (state == ST_WR_HOLD);

  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  input  logic [1:0]        req_be,
  input  logic              req_write,
  input  logic              x16,
  input  logic              sel,
  input  logic              drive_data,
  input  logic              sample_rd,
  input  logic [DQ_W-1:0]   mem_dq_i,
  output logic [ADDR_W-1:0] mem_a,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic [DQ_W-1:0]   mem_dq_oe,
  output logic [DQ_W-1:0]   rsp_rdata
);
  localparam int unsigned HALF = DQ_W / 2;

  logic [ADDR_W:0]  addr_q;
  logic [DQ_W-1:0]  wdata_q;
  logic [1:0]       be_q;
  logic             wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_rdata <= '0;
    else if (sample_rd) rsp_rdata <= x16 ? mem_dq_i : {{HALF{1'b0}}, mem_dq_i[HALF-1:0]};
  end

  assign mem_a = x16 ? addr_q[ADDR_W-1:0] : addr_q[ADDR_W:1];

  // lane strobes: reads and byte mode use every lane, word writes follow the enables
  logic [1:0] lane_on;
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_on[g] = sel & (~x16 | ~wr_q | be_q[g]);
  end
  assign mem_lb_n = ~lane_on[0];
  assign mem_ub_n = ~lane_on[1];

  // byte mode: top pin carries the address LSB, upper data lanes float
  always_comb begin
    if (x16) begin
      mem_dq_o  = wdata_q;
      mem_dq_oe = {DQ_W{drive_data}};
    end else begin
      mem_dq_o  = {addr_q[0], {(HALF-1){1'b0}}, wdata_q[HALF-1:0]};
      mem_dq_oe = {1'b1, {(HALF-1){1'b0}}, {HALF{drive_data}}};
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned T_AA_NS   = 40,
  parameter int unsigned T_RC_NS   = 40,
  parameter int unsigned T_WP_NS   = 30,
  parameter int unsigned T_CW_NS   = 35,
  parameter int unsigned T_DW_NS   = 20,
  parameter int unsigned T_HZ_NS   = 20,
  parameter int unsigned T_MODE_NS = 5_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_byte,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ack,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_a,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_rw,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic              mem_x16,
  output logic [15:0]       mem_dq_o,
  output logic [15:0]       mem_dq_oe,
  input  logic [15:0]       mem_dq_i
);
  localparam int unsigned RD_CYC   = at_least_one(max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS)));
  localparam int unsigned HZ_CYC   = at_least_one(ns_to_cyc(T_HZ_NS, CLK_NS));
  localparam int unsigned DS_CYC   = at_least_one(ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int unsigned STB_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS));
  localparam int unsigned WD_CYC   = wr_data_cyc(DS_CYC, STB_CYC, HZ_CYC);
  localparam int unsigned MODE_CYC = at_least_one(ns_to_cyc(T_MODE_NS, CLK_NS));
  localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, MODE_CYC), max2(HZ_CYC, WD_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic             t_load, t_done;
  logic [CNT_W-1:0] t_val;
  logic             accept, sample_rd, sel, rd_act, wr_act, drive_data;

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  sram_ctl_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC), .WD_CYC(WD_CYC), .MODE_CYC(MODE_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .t_done(t_done), .t_load(t_load), .t_val(t_val),
    .accept(accept), .sample_rd(sample_rd), .ack(req_ack), .x16(mem_x16),
    .sel(sel), .rd_act(rd_act), .wr_act(wr_act), .drive_data(drive_data)
  );

  sram_ctl_lanes #(.ADDR_W(ADDR_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write), .x16(mem_x16),
    .sel(sel), .drive_data(drive_data), .sample_rd(sample_rd), .mem_dq_i(mem_dq_i),
    .mem_a(mem_a), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .rsp_rdata(rsp_rdata)
  );

  assign mem_ce1_n = ~sel;
  assign mem_ce2   = sel;
  assign mem_oe_n  = ~rd_act;
  assign mem_rw    = ~wr_act;

  // driven-data cycles inside the current write strobe
  logic [CNT_W:0] ds_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ds_run <= '0;
    else if (!wr_act)              ds_run <= '0;
    else if (mem_dq_oe[0])         ds_run <= ds_run + 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !drive_data) |-> (mem_dq_oe[7:0] == 8'h00 && mem_oe_n && mem_rw));
  // R2
  rd_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_rd |-> (!mem_oe_n && mem_rw && !mem_ce1_n && mem_ce2));
  // R4
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rw) |-> (mem_dq_oe[7:0] == 8'h00));
  // R4
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rw) |-> (ds_run >= (CNT_W+1)'(DS_CYC)));
  // R5
  rd_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (mem_dq_oe[7:0] == 8'h00));
  // R9
  mode_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_x16) |-> (mem_ce1_n && $past(mem_ce1_n)));
endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
  // restated timing at 20 ns period: access 2, release 1, setup 1, strobe 2, settle 5
  localparam int ACC_CYC  = 2;
  localparam int STB_CYC  = 2;
  localparam int DS_CYC   = 1;
  localparam int MODE_CYC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ack;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_a;
  logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_rw, mem_lb_n, mem_ub_n, mem_x16;
  logic [15:0] mem_dq_o, mem_dq_oe, mem_dq_i;

  sram_ctl #(.T_MODE_NS(100)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .mem_a(mem_a), .mem_ce1_n(mem_ce1_n),
    .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_rw(mem_rw), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_x16(mem_x16), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int checks = 0, errors = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem8 [0:255];
  logic [7:0] sh8  [0:255];
  wire sel_w = !mem_ce1_n && mem_ce2;
  wire rd_w  = sel_w && mem_rw && !mem_oe_n;
  wire wr_w  = sel_w && !mem_rw;
  wire [7:0] wbase = {mem_a[6:0], 1'b0};
  wire [7:0] bidx  = {mem_a[6:0], mem_dq_o[15]};

  int rd_stable = 0, wp_cnt = 0, wdrv_cnt = 0;
  int desel_cnt = 100, since_flip = 1000, flips = 0;
  int r3_bad = 0, r4_bad = 0, r5_bad = 0, r7_bad = 0, r9_bad = 0;
  logic prev_rd = 0, prev_wr = 0, prev_sel = 0, prev_oe_low = 0, prev_x16 = 1;
  logic [18:0] prev_a = '0, seen_a = '0;
  logic        seen_lsb = 0;
  logic [7:0]  w_base, w_bidx;
  logic [15:0] w_data;
  logic        w_x16, w_lb_n, w_ub_n;

  always_comb begin
    mem_dq_i = 16'hDEAD;
    if (rd_w && rd_stable >= ACC_CYC - 1) begin
      if (mem_x16) mem_dq_i = {mem8[wbase | 8'd1], mem8[wbase]};
      else         mem_dq_i = {8'hEE, mem8[bidx]};
    end
  end

  always @(posedge clk) if (rst_n) begin
    prev_rd     <= rd_w;
    prev_a      <= mem_a;
    rd_stable   <= rd_w ? ((prev_rd && prev_a == mem_a) ? rd_stable + 1 : 1) : 0;
    prev_oe_low <= !mem_oe_n;
    prev_sel    <= sel_w;
    prev_x16    <= mem_x16;
    prev_wr     <= wr_w;
    if (sel_w) begin seen_a <= mem_a; seen_lsb <= mem_dq_o[15]; end
    // R5: no drive while OE low or in the cycle after it rises
    if ((!mem_oe_n || prev_oe_low) && mem_dq_oe[7:0] != 8'h00) r5_bad <= r5_bad + 1;
    // R7: byte mode pin usage
    if (!mem_x16 && (mem_dq_oe[14:8] != 7'h00 || !mem_dq_oe[15])) r7_bad <= r7_bad + 1;
    // R9: settle windows around the width flip
    desel_cnt <= sel_w ? 0 : desel_cnt + 1;
    if (mem_x16 != prev_x16) begin
      flips <= flips + 1;
      since_flip <= 1;
      if (sel_w || desel_cnt < MODE_CYC) r9_bad <= r9_bad + 1;
    end else if (since_flip < 1000) since_flip <= since_flip + 1;
    if (sel_w && !prev_sel && since_flip < MODE_CYC) r9_bad <= r9_bad + 1;
    // writes
    if (wr_w) begin
      if (!prev_wr && mem_dq_oe[7:0] != 8'h00) r4_bad <= r4_bad + 1;
      wp_cnt   <= prev_wr ? wp_cnt + 1 : 1;
      wdrv_cnt <= (prev_wr ? wdrv_cnt : 0) + (mem_dq_oe[0] ? 1 : 0);
      w_base <= wbase; w_bidx <= bidx; w_data <= mem_dq_o;
      w_x16 <= mem_x16; w_lb_n <= mem_lb_n; w_ub_n <= mem_ub_n;
    end else if (prev_wr) begin
      if (wp_cnt < STB_CYC) r3_bad <= r3_bad + 1;
      if (wdrv_cnt < DS_CYC || mem_dq_oe[0] !== 1'b1) r4_bad <= r4_bad + 1;
      if (!w_x16) mem8[w_bidx] <= w_data[7:0];
      else begin
        if (!w_lb_n) mem8[w_base]        <= w_data[7:0];
        if (!w_ub_n) mem8[w_base | 8'd1] <= w_data[15:8];
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { bit rd; logic [15:0] data; string tag; } exp_t;
  exp_t exp_q[$];
  int reqs = 0, acks = 0;

  always @(negedge clk) if (rst_n && req_ack) begin
    acks++;
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R10 actual=unexpected ack expected=no ack");
    end else begin
      exp_t it;
      it = exp_q.pop_front();
      if (it.rd) chk(it.tag, {16'h0, rsp_rdata}, {16'h0, it.data});
    end
  end

  task automatic do_req(input bit wr, input bit byt, input logic [19:0] addr,
                        input logic [15:0] wd, input logic [1:0] be, input string tag);
    exp_t it;
    logic [7:0] lo;
    lo = {addr[6:0], 1'b0};
    it.rd = !wr; it.tag = tag; it.data = '0;
    if (byt) begin
      if (wr) sh8[addr[7:0]] = wd[7:0];
      else    it.data = {8'h00, sh8[addr[7:0]]};
    end else begin
      if (wr) begin
        if (be[0]) sh8[lo]        = wd[7:0];
        if (be[1]) sh8[lo | 8'd1] = wd[15:8];
      end else it.data = {sh8[lo | 8'd1], sh8[lo]};
    end
    exp_q.push_back(it);
    reqs++;
    req_valid = 1'b1; req_write = wr; req_byte = byt;
    req_addr = addr; req_wdata = wd; req_be = be;
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
    if (byt) chk({tag, " addr"}, {12'h0, seen_a, seen_lsb}, {12'h0, addr});
    else     chk({tag, " addr"}, {13'h0, seen_a}, {13'h0, addr[18:0]});
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem8[i] = 8'(i) ^ 8'h5A; sh8[i] = 8'(i) ^ 8'h5A; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ce1_n", {31'h0, mem_ce1_n}, 1);
    chk("R1 ce2",   {31'h0, mem_ce2},   0);
    chk("R1 oe_n",  {31'h0, mem_oe_n},  1);
    chk("R1 rw",    {31'h0, mem_rw},    1);
    chk("R1 dq_oe", {16'h0, mem_dq_oe}, 0);
    chk("R1 x16",   {31'h0, mem_x16},   1);
    chk("R1 ack",   {31'h0, req_ack},   0);

    do_req(1, 0, 20'h00005, 16'hA1B2, 2'b11, "R3");
    do_req(0, 0, 20'h00005, 16'h0,    2'b11, "R2");
    do_req(1, 0, 20'h00006, 16'h1234, 2'b01, "R6");
    do_req(0, 0, 20'h00006, 16'h0,    2'b11, "R6");
    do_req(1, 0, 20'h00007, 16'h5678, 2'b10, "R6");
    do_req(0, 0, 20'h00007, 16'h0,    2'b11, "R6");
    do_req(1, 0, 20'h7FF40, 16'hC0DE, 2'b11, "R8");
    do_req(0, 0, 20'h7FF40, 16'h0,    2'b11, "R8");
    // width change into byte mode (R9), byte addressing (R8), pin use (R7)
    do_req(1, 1, 20'h00015, 16'hFF77, 2'b00, "R8");
    do_req(0, 1, 20'h00015, 16'h0,    2'b00, "R8");
    do_req(0, 1, 20'h00014, 16'h0,    2'b00, "R7");
    do_req(1, 1, 20'hFFF03, 16'h00C3, 2'b00, "R8");
    do_req(0, 1, 20'hFFF03, 16'h0,    2'b00, "R8");
    // back to word mode: upper byte of word 10 is the byte written at 0x15
    do_req(0, 0, 20'h0000A, 16'h0,    2'b11, "R9");
    // back-to-back traffic, each request raised while the previous one finishes (R10)
    for (int i = 0; i < 6; i++) do_req(1, 0, 20'h00020 + 20'(i), 16'h1111 * 16'(i + 1), 2'b11, "R10");
    for (int i = 0; i < 6; i++) do_req(0, 0, 20'h00020 + 20'(i), 16'h0, 2'b11, "R10");
    do_req(1, 1, 20'h00041, 16'h0099, 2'b00, "R10");
    do_req(0, 0, 20'h00020, 16'h0,    2'b11, "R10");
    repeat (4) @(negedge clk);

    chk("R3 strobe length",   r3_bad, 0);
    chk("R4 data drive",      r4_bad, 0);
    chk("R5 read turnaround", r5_bad, 0);
    chk("R7 byte-mode pins",  r7_bad, 0);
    chk("R9 settle windows",  r9_bad, 0);
    chk("R9 flip count",      flips,  4);
    chk("R10 ack count",      acks,   reqs);
    chk("R10 queue empty",    exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule